// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a general-purpose timer that sits on a simple 32-bit register bus. A 32-bit up-counter advances on qualified tick pulses. Each tick comes from one of two synchronous clock-enable strobes: a peripheral tick or an oscillator tick. A source code in the control word picks the strobe, and each strobe has its own prescaler field of a different width. The counter is readable at any moment and wraps from all-ones to zero.

Software programs the prescaler word first, then writes the control word with the enable bit set and a valid source code. A self-clearing soft-reset bit returns the control state and the count to zero after a short fixed sequence. Status, interrupt, three compare and two capture words exist only as read/write storage; they do not affect counting.

Top module: `tick_timer`

## Requirements
- R1: After reset every mapped word reads zero, including control (offset 0x00), prescaler (0x04), storage words and counter (0x24).
- R2: Word offsets are: 0x00 control, 0x04 prescaler, 0x08 status, 0x0C interrupt, 0x10/0x14/0x18 compare 1-3, 0x1C/0x20 capture 1-2, and 0x24 counter. The counter word is read-only and ignores writes. The seven storage words read back the last 32-bit value written. The prescaler word keeps bits 15:0 and reads zero above them.
- R3: The control word keeps these bits: bit 0 enable, bits 8:6 source code, bit 9 free-run, bit 10 oscillator enable and bit 15 soft reset. All other bits read 0.
- R4: Source code 1 counts peripheral ticks, divided by prescaler bits 11:0. Source code 5 counts oscillator ticks, divided by prescaler bits 15:12, but only while the oscillator-enable bit is 1. Any other source code stops counting. Ticks of the unselected source have no effect.
- R5: A prescaler field of value N advances the counter once per N+1 selected ticks. The count changes on the clock edge that samples the (N+1)-th tick, and a read in the next cycle returns it. Ticks need not be consecutive.
- R6: The counter wraps from all-ones to zero. Its width is the CNT_W parameter (32 by default), and it reads zero-extended.
- R7: While enable is 0 the counter holds its value and the internal prescaler count is cleared. Division therefore restarts from a clean boundary when enable returns.
- R8: Any write to the prescaler word clears the internal prescaler count.
- R9: Writing 1 to bit 15 starts a soft reset. The write's other bits are dropped. Bit 15 reads 1 for the 4 cycles after the write edge, while the older control bits still read unchanged. In that window control writes are ignored and no counting occurs. At the end, the control bits, the counter and the prescaler count are all zero. The prescaler word and the storage words keep their values.
- R10: Reads from offsets above 0x24, or with address bits 1:0 non-zero, return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| per_tick | input | 1 | Peripheral tick strobe |
| osc_tick | input | 1 | Oscillator tick strobe |

## Verification
Read data is combinational, so each read shows the state left by the last clock edge. A write takes effect on the edge that samples it. A tick that completes a division updates the counter on that same edge, and the result can be read in the following cycle. Bit 15 stays set on reads taken after the write edge and after the next three edges, and drops after the fourth. The bench drives every bus operation and tick at a falling edge and holds it for exactly one rising edge. A monitor compares each read two time units after that falling edge against a value queued by the driver. This lets back-to-back operations step through the soft-reset window one cycle at a time.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = 16;
    localparam int PER_DIV_W  = 12;
    localparam int OSC_DIV_W  = 4;
    localparam int SRC_W      = 3;
    localparam int IDX_W      = 4;

    localparam logic [SRC_W-1:0] SRC_PERIPH = 3'd1;
    localparam logic [SRC_W-1:0] SRC_OSC    = 3'd5;

    localparam int B_EN     = 0;
    localparam int B_SRC_LO = 6;
    localparam int B_FREE   = 9;
    localparam int B_OSCEN  = 10;
    localparam int B_SWRST  = 15;

    localparam int W_CTRL      = 0;
    localparam int W_PRESC     = 1;
    localparam int W_STORE_LO  = 2;
    localparam int NUM_STORE   = 7;
    localparam int W_COUNT     = 9;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic             free_run;
        logic             osc_en;
    } ctrl_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
    import tick_timer_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [HALF_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int RC_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;

    typedef struct packed {
        ctrl_t           ctrl;
        logic            busy;
        logic [RC_W-1:0] rcnt;
    } st_t;

    st_t st_d, st_q;
    logic done_d;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        if (st_q.busy) begin
            if (st_q.rcnt == '0) begin
                st_d.busy = 1'b0;
                st_d.ctrl = '0;
                done_d    = 1'b1;
            end else begin
                st_d.rcnt = st_q.rcnt - 1'b1;
            end
        end else if (wr_i) begin
            if (wdata_i[B_SWRST]) begin
                st_d.busy = 1'b1;
                st_d.rcnt = RC_W'(RST_CYC - 1);
            end else begin
                st_d.ctrl.en       = wdata_i[B_EN];
                st_d.ctrl.src      = wdata_i[B_SRC_LO +: SRC_W];
                st_d.ctrl.free_run = wdata_i[B_FREE];
                st_d.ctrl.osc_en   = wdata_i[B_OSCEN];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign busy_o = st_q.busy;
    assign done_o = done_d;

    // R9: control fields frozen while the soft reset is still running
    a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !done_d) |=> $stable(st_q.ctrl));

    // R9: completion leaves every control field at zero
    a_r9_ctrl_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (st_q.ctrl == '0));

endmodule

// File: rtl/tick_timer_presc.sv
module tick_timer_presc
    import tick_timer_pkg::*;
#(
    parameter int PER_W = PER_DIV_W,
    parameter int OSC_W = OSC_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic             osc_en_i,
    input  logic             per_tick_i,
    input  logic             osc_tick_i,
    input  logic [PER_W-1:0] per_div_i,
    input  logic [OSC_W-1:0] osc_div_i,
    output logic             adv_o
);

    localparam int PC_W = (PER_W > OSC_W) ? PER_W : OSC_W;

    typedef struct packed {
        logic [PC_W-1:0] pcnt;
    } st_t;

    st_t st_d, st_q;
    logic            tick_sel;
    logic [PC_W-1:0] div_sel;
    logic            adv_d;

    always_comb begin
        tick_sel = 1'b0;
        div_sel  = '0;
        if (src_i == SRC_PERIPH) begin
            tick_sel = per_tick_i;
            div_sel  = PC_W'(per_div_i);
        end else if (src_i == SRC_OSC && osc_en_i) begin
            tick_sel = osc_tick_i;
            div_sel  = PC_W'(osc_div_i);
        end
    end

    always_comb begin
        st_d  = st_q;
        adv_d = 1'b0;
        if (clr_i || !run_i) begin
            st_d.pcnt = '0;
        end else if (tick_sel) begin
            if (st_q.pcnt >= div_sel) begin
                st_d.pcnt = '0;
                adv_d     = 1'b1;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign adv_o = adv_d;

    // R7: no advance while stopped
    a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !adv_o);

    // R4: an advance needs a tick of the selected, enabled source
    a_r4_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> ((src_i == SRC_PERIPH && per_tick_i) ||
                   (src_i == SRC_OSC && osc_en_i && osc_tick_i)));

    // R8: a prescaler write leaves the division count at zero
    a_r8_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.pcnt == '0));

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)      st_d.cnt = '0;
        else if (adv_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R7: without an advance the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(st_q.cnt));

    // R6: one advance adds exactly one, wrapping modulo 2**CNT_W
    a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              per_tick,
    input  logic              osc_tick
);

    typedef struct packed {
        logic [HALF_W-1:0]                presc;
        logic [NUM_STORE-1:0][DATA_W-1:0] store;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] word_idx;
    logic             aligned, mapped;
    logic             wr_hit, rd_hit;
    logic             ctrl_wr, presc_wr;
    ctrl_t            ctrl;
    logic             busy, done;
    logic             adv;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] ctrl_rd, cnt_rd;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign mapped   = aligned && (word_idx <= IDX_W'(W_COUNT));
    assign wr_hit   = bus_sel && bus_wr && mapped;
    assign rd_hit   = bus_sel && !bus_wr && mapped;
    assign ctrl_wr  = wr_hit && (word_idx == IDX_W'(W_CTRL));
    assign presc_wr = wr_hit && (word_idx == IDX_W'(W_PRESC));

    always_comb begin
        st_d = st_q;
        if (presc_wr) st_d.presc = bus_wdata[HALF_W-1:0];
        for (int g = 0; g < NUM_STORE; g++) begin
            if (wr_hit && word_idx == IDX_W'(g + W_STORE_LO)) st_d.store[g] = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tick_timer_ctrl #(
        .RST_CYC (RST_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr),
        .wdata_i (bus_wdata[HALF_W-1:0]),
        .ctrl_o  (ctrl),
        .busy_o  (busy),
        .done_o  (done)
    );

    tick_timer_presc #(
        .PER_W (PER_DIV_W),
        .OSC_W (OSC_DIV_W)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl.en && !busy),
        .clr_i      (presc_wr || done),
        .src_i      (ctrl.src),
        .osc_en_i   (ctrl.osc_en),
        .per_tick_i (per_tick),
        .osc_tick_i (osc_tick),
        .per_div_i  (st_q.presc[PER_DIV_W-1:0]),
        .osc_div_i  (st_q.presc[PER_DIV_W +: OSC_DIV_W]),
        .adv_o      (adv)
    );

    tick_timer_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (adv),
        .clr_i (done),
        .cnt_o (cnt)
    );

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[B_EN]                = ctrl.en;
        ctrl_rd[B_SRC_LO +: SRC_W]   = ctrl.src;
        ctrl_rd[B_FREE]              = ctrl.free_run;
        ctrl_rd[B_OSCEN]             = ctrl.osc_en;
        ctrl_rd[B_SWRST]             = busy;
        cnt_rd = '0;
        cnt_rd[CNT_W-1:0]            = cnt;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            if (word_idx == IDX_W'(W_CTRL))  bus_rdata = ctrl_rd;
            if (word_idx == IDX_W'(W_PRESC)) bus_rdata = DATA_W'(st_q.presc);
            if (word_idx == IDX_W'(W_COUNT)) bus_rdata = cnt_rd;
            for (int g = 0; g < NUM_STORE; g++) begin
                if (word_idx == IDX_W'(g + W_STORE_LO)) bus_rdata = st_q.store[g];
            end
        end
    end

    // R10: unmapped or misaligned reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !mapped) |-> (bus_rdata == '0));

    // R9: no count advance during the soft-reset window
    a_r9_no_count_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !adv);

    // R9: count is zero once the soft reset completes
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '0));

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        per_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic        mon_rd = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.CNT_W(CNT_W), .RST_CYC(4)) u_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .per_tick  (per_tick),
        .osc_tick  (osc_tick)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; mon_rd = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; mon_rd = 1'b0;
    endtask

    task automatic ticks(input bit p, input bit o, input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            per_tick = p; osc_tick = o;
            @(posedge clk); #1;
            per_tick = 1'b0; osc_tick = 1'b0;
            if (gap) @(posedge clk);
        end
    endtask

    // monitor: compare every read against the queued expectation
    initial begin
        forever begin
            @(negedge clk); #2;
            if (mon_rd) begin
                exp_t it;
                n_checks++;
                if (sb_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL scoreboard empty: got 0x%08h expected none", bus_rdata);
                end else begin
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.val) begin
                        n_fails++;
                        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, bus_rdata, it.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, 32'h0, "R1 ctrl");
        rd(6'h04, 32'h0, "R1 presc");
        rd(6'h24, 32'h0, "R1 counter");
        rd(6'h08, 32'h0, "R1 status");

        // R3 field mask
        wr(6'h00, 32'hFFFF_7FFF);
        rd(6'h00, 32'h0000_07C1, "R3 ctrl mask");
        wr(6'h00, 32'h0);

        // R2 map and storage
        wr(6'h10, 32'hDEAD_BEEF);
        rd(6'h10, 32'hDEAD_BEEF, "R2 compare1");
        wr(6'h20, 32'h1234_5678);
        rd(6'h20, 32'h1234_5678, "R2 capture2");
        wr(6'h24, 32'h0000_00FF);
        rd(6'h24, 32'h0, "R2 counter read-only");
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, 32'h0000_FFFF, "R2 presc width");

        // R10 unmapped
        wr(6'h28, 32'hFFFF_FFFF);
        wr(6'h11, 32'h0);
        rd(6'h28, 32'h0, "R10 unmapped read");
        rd(6'h3C, 32'h0, "R10 top offset read");
        rd(6'h11, 32'h0, "R10 misaligned read");
        rd(6'h10, 32'hDEAD_BEEF, "R10 no side effect");

        // R5 division by 3 on peripheral source
        wr(6'h04, 32'h2);
        wr(6'h00, 32'h241);
        ticks(1, 0, 9, 0);
        rd(6'h24, 32'd3, "R5 div3 back-to-back");
        ticks(1, 0, 6, 1);
        rd(6'h24, 32'd5, "R5 div3 spaced ticks");

        // R4 source selection
        ticks(0, 1, 5, 0);
        rd(6'h24, 32'd5, "R4 unselected osc");
        wr(6'h00, 32'h2C1);
        ticks(1, 0, 6, 0);
        rd(6'h24, 32'd5, "R4 invalid source");
        wr(6'h00, 32'h241);

        // R7 enable clear drops partial division
        ticks(1, 0, 2, 0);
        wr(6'h00, 32'h240);
        ticks(1, 0, 4, 0);
        rd(6'h24, 32'd5, "R7 hold disabled");
        wr(6'h00, 32'h241);
        ticks(1, 0, 2, 0);
        rd(6'h24, 32'd5, "R7 clean restart");
        ticks(1, 0, 1, 0);
        rd(6'h24, 32'd6, "R7 first advance");

        // R8 prescaler write clears partial division
        ticks(1, 0, 2, 0);
        wr(6'h04, 32'h2);
        ticks(1, 0, 2, 0);
        rd(6'h24, 32'd6, "R8 restart after write");
        ticks(1, 0, 1, 0);
        rd(6'h24, 32'd7, "R8 advance");

        // R4 oscillator source with its own field
        wr(6'h04, 32'h0000_10FF);
        wr(6'h00, 32'h341);
        ticks(0, 1, 6, 0);
        rd(6'h24, 32'd7, "R4 osc gated off");
        wr(6'h00, 32'h741);
        ticks(0, 1, 6, 0);
        rd(6'h24, 32'd10, "R4 osc div2");
        ticks(1, 0, 6, 0);
        rd(6'h24, 32'd10, "R4 unselected periph");

        // R9 soft reset window, back-to-back operations
        wr(6'h00, 32'h0000_8000);
        rd(6'h00, 32'h0000_8741, "R9 busy cycle1");
        wr(6'h00, 32'h0000_0241);
        rd(6'h00, 32'h0000_8741, "R9 busy cycle3 write ignored");
        rd(6'h00, 32'h0000_8741, "R9 busy cycle4");
        rd(6'h00, 32'h0, "R9 self clear");
        rd(6'h24, 32'h0, "R9 counter cleared");
        rd(6'h04, 32'h0000_10FF, "R9 presc kept");
        rd(6'h10, 32'hDEAD_BEEF, "R9 storage kept");

        // R6 wrap with no division
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h241);
        ticks(1, 0, 255, 0);
        rd(6'h24, 32'h0000_00FF, "R6 all ones");
        ticks(1, 0, 1, 0);
        rd(6'h24, 32'h0, "R6 wrap to zero");
        ticks(1, 0, 1, 0);
        rd(6'h24, 32'h1, "R5 div1 after wrap");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fails++;
            $display("FAIL scoreboard leftover: got %0d expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule